// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block computes one byte-wide arithmetic, logic, shift or nibble-swap operation per cycle on two operand bytes. Both operands are plain bytes, so the block does not care whether the second one came from a register or an immediate field. The result byte, its write enable and the flag write mask are combinational. The six status flags sit in a register inside the block and update on the clock edge when an operation is presented.

Each operation owns a fixed subset of the flags. It writes only that subset and holds every other flag. Increment and decrement leave carry alone, so they can drive multi-byte loop counters. Subtract-with-carry and compare-with-carry can only keep or clear zero, so a chain of byte operations gives a zero flag for the whole word. Compares set flags but suppress the result write. Unary operations work on `opnd_a` and ignore `opnd_b`.

Flag vector layout (used by `flag_mask`, `flag_next` and `flags_o`): bit 0 C (carry/borrow), bit 1 Z (zero), bit 2 N (bit 7 of result), bit 3 V (signed overflow), bit 4 S (N xor V), bit 5 H (carry/borrow across bit 3).

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `flags_o` is cleared to 0. The flag bits sit at C=0, Z=1, N=2, V=3, S=4, H=5.
- R2: Code 0 (add) returns A+B and code 1 (add with carry) returns A+B+C. Both write all six flags: C is the carry out of bit 7, H the carry out of bit 3, V signed overflow.
- R3: Code 2 (subtract) returns A-B and code 3 (subtract with carry) returns A-B-C. Both write all six flags: C is the borrow out of bit 7, H the borrow out of bit 3, V signed overflow. For code 3, Z is set only if the result is zero and Z was already set.
- R4: Code 11 (compare) and code 12 (compare with carry) produce the same flags as codes 2 and 3, including the Z rule for code 12, and keep `result_we` low.
- R5: Codes 4, 5 and 6 (AND, OR, XOR) return the bitwise result, clear V and write only Z, N, V and S.
- R6: Code 7 (complement) returns 0xFF-A, sets C, clears V and writes Z, C, N, V and S. Code 8 (negate) returns 0x00-A and writes all six flags: C is set when the result is nonzero, H is the borrow out of bit 3, and V is set when A is 0x80.
- R7: Code 9 (increment) returns A+1 and code 10 (decrement) returns A-1. Both write only Z, N, V and S, so C and H are held. V is set on 0x7F to 0x80 for increment and on 0x80 to 0x7F for decrement.
- R8: Code 13 (shift left) feeds 0 into bit 0, code 14 (shift right) feeds 0 into bit 7, code 15 (rotate left) feeds the old C into bit 0, and code 16 (rotate right) feeds the old C into bit 7. The bit shifted out goes to C, V equals N xor C, and the flags written are Z, C, N, V and S.
- R9: Code 17 (arithmetic right shift) keeps bit 7, moves bits 7..1 into bits 6..0, puts old bit 0 into C, sets V to N xor C, and writes Z, C, N, V and S.
- R10: Code 18 (nibble swap) exchanges bits 7..4 with bits 3..0, writes the result, and has a flag mask of 0.
- R11: `flag_next` equals the held flags outside `flag_mask` and the new values inside it. S is always N xor V. `flags_o` takes `flag_next` on the clock edge when `op_valid` is high.
- R12: While `op_valid` is low, `flags_o` holds and `result_we` is low. Codes 19 to 31 return 0 with `result_we` low and a mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| opnd_a | input | 8 | First operand; the only operand of unary operations |
| opnd_b | input | 8 | Second operand, register or immediate |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result byte should be written back |
| flag_mask | output | 6 | Flags this operation writes |
| flag_next | output | 6 | Flag vector after this operation |
| flags_o | output | 6 | Registered status flags |

## Verification
On every cycle the assertions check that flags outside the mask are held and that S stays equal to N xor V. They also check that compares never request a write, that increment and decrement keep carry, that a chained subtract never sets a clear Z, and that a swap moves nibbles without touching flags. Only the bench's sweeps can show that the values are right: every first operand against boundary second operands, with each combination of incoming carry and zero, checked against arithmetic computed in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_CMP  = 5'd11,
        OP_CPC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          hc,
    output logic          ovf
);
    localparam int HB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   full_sum;
    logic [HB:0]   half_sum;

    always_comb begin
        // subtraction as a + ~b + ~borrow; carry out inverted gives borrow
        b_eff    = sub ? ~b : b;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        half_sum = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
        res      = full_sum[DW-1:0];
        cout     = full_sum[DW] ^ sub;
        hc       = half_sum[HB] ^ sub;
        ovf      = (a[DW-1] == b_eff[DW-1]) && (full_sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam int HALF = DW / 2;

    always_comb begin
        res  = a;
        cout = cin;
        unique case (op)
            OP_LSL: begin
                res  = {a[DW-2:0], 1'b0};
                cout = a[DW-1];
            end
            OP_LSR: begin
                res  = {1'b0, a[DW-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[DW-2:0], cin};
                cout = a[DW-1];
            end
            OP_ROR: begin
                res  = {cin, a[DW-1:1]};
                cout = a[0];
            end
            OP_ASR: begin
                res  = {a[DW-1], a[DW-1:1]};
                cout = a[0];
            end
            OP_SWAP: begin
                res  = {a[HALF-1:0], a[DW-1:HALF]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    output logic [DW-1:0]     result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flag_mask,
    output logic [FLAG_W-1:0] flag_next,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] M_ALL   = '1;
    localparam logic [FLAG_W-1:0] M_ZCNVS = FLAG_W'((1 << FC) | (1 << FZ) | (1 << FN) | (1 << FV) | (1 << FS));
    localparam logic [FLAG_W-1:0] M_ZNVS  = FLAG_W'((1 << FZ) | (1 << FN) | (1 << FV) | (1 << FS));
    localparam logic [DW-1:0]     ONE     = DW'(1);

    alu_op_e             op_e;
    flags_t              cur;
    flags_t              nf;
    logic [FLAG_W-1:0]   flags_q;
    logic [FLAG_W-1:0]   nf_v;
    logic [FLAG_W-1:0]   mask_c;
    logic [DW-1:0]       res_c;
    logic                wr_c;
    logic                z_chain;

    logic [DW-1:0]       as_a;
    logic [DW-1:0]       as_b;
    logic                as_sub;
    logic                as_cin;
    logic [DW-1:0]       as_res;
    logic                as_c;
    logic                as_h;
    logic                as_v;
    logic [DW-1:0]       lg_res;
    logic [DW-1:0]       sh_res;
    logic                sh_c;

    assign op_e = alu_op_e'(op_code);
    assign cur  = flags_t'(flags_q);

    // operand steering for the shared adder
    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_sub = 1'b0;
        as_cin = 1'b0;
        unique case (op_e)
            OP_ADC: as_cin = cur.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = cur.c;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = opnd_a;
                as_sub = 1'b1;
            end
            OP_INC: as_b = ONE;
            OP_DEC: begin
                as_b   = ONE;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a    (as_a),
        .b    (as_b),
        .sub  (as_sub),
        .cin  (as_cin),
        .res  (as_res),
        .cout (as_c),
        .hc   (as_h),
        .ovf  (as_v)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (lg_res)
    );

    alu8_shift #(.DW(DW)) u_shift (
        .op   (op_e),
        .a    (opnd_a),
        .cin  (cur.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    // result, write enable, mask and new flag values
    always_comb begin
        res_c   = '0;
        wr_c    = 1'b0;
        mask_c  = '0;
        nf      = cur;
        z_chain = 1'b0;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res_c   = as_res;
                wr_c    = 1'b1;
                mask_c  = M_ALL;
                nf.c    = as_c;
                nf.h    = as_h;
                nf.v    = as_v;
                z_chain = (op_e == OP_SBC);
            end
            OP_CMP, OP_CPC: begin
                res_c   = as_res;
                mask_c  = M_ALL;
                nf.c    = as_c;
                nf.h    = as_h;
                nf.v    = as_v;
                z_chain = (op_e == OP_CPC);
            end
            OP_INC, OP_DEC: begin
                res_c  = as_res;
                wr_c   = 1'b1;
                mask_c = M_ZNVS;
                nf.v   = as_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_c  = lg_res;
                wr_c   = 1'b1;
                mask_c = M_ZNVS;
                nf.v   = 1'b0;
            end
            OP_COM: begin
                res_c  = ~opnd_a;
                wr_c   = 1'b1;
                mask_c = M_ZCNVS;
                nf.c   = 1'b1;
                nf.v   = 1'b0;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_c  = sh_res;
                wr_c   = 1'b1;
                mask_c = M_ZCNVS;
                nf.c   = sh_c;
                nf.v   = sh_res[DW-1] ^ sh_c;
            end
            OP_SWAP: begin
                res_c = sh_res;
                wr_c  = 1'b1;
            end
            default: ;
        endcase
        nf.n = res_c[DW-1];
        nf.z = (res_c == '0) && (!z_chain || cur.z);
        nf.s = nf.n ^ nf.v;
    end

    assign nf_v      = nf;
    assign result    = res_c;
    assign result_we = wr_c & op_valid;
    assign flag_mask = mask_c;
    assign flag_next = (flags_q & ~mask_c) | (nf_v & mask_c);
    assign flags_o   = flags_q;

    // status flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_valid) begin
            flags_q <= flag_next;
        end
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DW-1:0]     opnd_a,
    input logic [DW-1:0]     result,
    input logic              result_we,
    input logic [FLAG_W-1:0] flag_mask,
    input logic [FLAG_W-1:0] flags_o
);
    localparam int HALF = DW / 2;

    // R11
    held_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((flags_o ^ $past(flags_o)) & ~$past(flag_mask)) == '0);

    // R11
    sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FS] == (flags_o[FN] ^ flags_o[FV]));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_o));

    // R4
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CMP || op_code == OP_CPC) |-> !result_we);

    // R7
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> flags_o[FC] == $past(flags_o[FC]));

    // R3
    zero_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_SBC || op_code == OP_CPC) && !flags_o[FZ]) |=> !flags_o[FZ]);

    // R10
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_SWAP) |-> (flag_mask == '0 && result == {opnd_a[HALF-1:0], opnd_a[DW-1:HALF]}));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .result    (result),
    .result_we (result_we),
    .flag_mask (flag_mask),
    .flags_o   (flags_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] result;
    logic       result_we;
    logic [5:0] flag_mask;
    logic [5:0] flag_next;
    logic [5:0] flags_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [5:0] exp_f = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .result_we (result_we),
        .flag_mask (flag_mask),
        .flag_next (flag_next),
        .flags_o   (flags_o)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1:           return "R2";
            2, 3:           return "R3";
            11, 12:         return "R4";
            4, 5, 6:        return "R5";
            7, 8:           return "R6";
            9, 10:          return "R7";
            13, 14, 15, 16: return "R8";
            17:             return "R9";
            18:             return "R10";
            default:        return "R12";
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // reference computed from the requirement text with integer arithmetic
    task automatic model(input int op, input int ia, input int ib, input logic [5:0] f,
                         input logic vld, output logic [7:0] r, output logic we,
                         output logic [5:0] m, output logic [5:0] nx);
        int t;
        int st;
        int ci;
        logic c, z, n, v, h, keep;
        logic [5:0] nv;
        ci = int'(f[0]);
        c = f[0]; v = f[3]; h = f[5];
        keep = 1'b0; we = 1'b1; m = 6'h00; t = 0;
        case (op)
            0, 1: begin
                if (op == 0) ci = 0;
                t = ia + ib + ci; st = sgn(ia) + sgn(ib) + ci;
                c = t > 255; h = (ia % 16 + ib % 16 + ci) > 15;
                v = (st > 127) || (st < -128); m = 6'h3F;
            end
            2, 3, 11, 12: begin
                if (op == 2 || op == 11) ci = 0;
                t = ia - ib - ci; st = sgn(ia) - sgn(ib) - ci;
                c = t < 0; h = (ia % 16 - ib % 16 - ci) < 0;
                v = (st > 127) || (st < -128); m = 6'h3F;
                keep = (op == 3 || op == 12); we = (op < 11);
            end
            4: begin t = int'(8'(ia) & 8'(ib)); v = 0; m = 6'h1E; end
            5: begin t = int'(8'(ia) | 8'(ib)); v = 0; m = 6'h1E; end
            6: begin t = int'(8'(ia) ^ 8'(ib)); v = 0; m = 6'h1E; end
            7: begin t = 255 - ia; c = 1; v = 0; m = 6'h1F; end
            8: begin
                t = 0 - ia; c = t < 0; h = (0 - ia % 16) < 0;
                v = (ia == 128); m = 6'h3F;
            end
            9:  begin t = ia + 1; v = (ia == 127); m = 6'h1E; end
            10: begin t = ia - 1; v = (ia == 128); m = 6'h1E; end
            13: begin t = (ia * 2) % 256;             c = ia >= 128;  m = 6'h1F; end
            14: begin t = ia / 2;                     c = ia % 2 == 1; m = 6'h1F; end
            15: begin t = (ia * 2) % 256 + ci;        c = ia >= 128;  m = 6'h1F; end
            16: begin t = ia / 2 + ci * 128;          c = ia % 2 == 1; m = 6'h1F; end
            17: begin t = ia / 2 + ((ia >= 128) ? 128 : 0); c = ia % 2 == 1; m = 6'h1F; end
            18: begin t = (ia % 16) * 16 + ia / 16; end
            default: begin t = 0; we = 1'b0; end
        endcase
        r = t[7:0];
        n = r[7];
        z = (r == 8'h00) && (!keep || f[1]);
        if (op >= 13 && op <= 17) v = n ^ c;
        nv = {h, n ^ v, v, n, z, c};
        nx = (f & ~m) | (nv & m);
        we = we & vld;
    endtask

    task automatic do_op(input int op, input int ia, input int ib, input logic vld);
        logic [7:0] er;
        logic       ewe;
        logic [5:0] em;
        logic [5:0] enx;
        @(negedge clk);
        op_code  = 5'(op);
        opnd_a   = 8'(ia);
        opnd_b   = 8'(ib);
        op_valid = vld;
        #2;
        model(op, ia, ib, exp_f, vld, er, ewe, em, enx);
        n_checks++;
        if (result_we !== ewe || flag_mask !== em || flag_next !== enx ||
            (ewe && result !== er) || (op > 18 && result !== 8'h00)) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%06b: res=%02h we=%b mask=%06b next=%06b expected res=%02h we=%b mask=%06b next=%06b",
                     req_of(op), op, ia[7:0], ib[7:0], exp_f, result, result_we, flag_mask,
                     flag_next, er, ewe, em, enx);
        end
        @(posedge clk);
        #1;
        if (vld) exp_f = enx;
        n_checks++;
        if (flags_o !== exp_f) begin
            n_fail++;
            $display("FAIL %s registered flags op=%0d valid=%b: flags=%06b expected %06b",
                     vld ? "R11" : "R12", op, vld, flags_o, exp_f);
        end
    endtask

    // drive C and Z to a chosen pair through normal operations
    task automatic set_cz(input logic c, input logic z);
        if (c) do_op(7, z ? 255 : 0, 0, 1'b1);
        else   do_op(0, z ? 0 : 1, 0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int blist[8];
        int bops[9];
        int uops[10];
        int b;
        blist = '{0, 1, 15, 16, 127, 128, 254, 255};
        bops  = '{0, 1, 2, 3, 4, 5, 6, 11, 12};
        uops  = '{7, 8, 9, 10, 13, 14, 15, 16, 17, 18};

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (flags_o !== 6'h00 || result_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: flags=%06b we=%b expected flags=000000 we=0", flags_o, result_we);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5: binary operations, every A against boundary B and B=A
        foreach (bops[k]) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 9; bi++) begin
                    b = (bi == 8) ? a : blist[bi];
                    if (bops[k] == 1 || bops[k] == 3 || bops[k] == 12) begin
                        for (int pc = 0; pc < 4; pc++) begin
                            set_cz(pc[0], pc[1]);
                            do_op(bops[k], a, b, 1'b1);
                        end
                    end else begin
                        do_op(bops[k], a, b, 1'b1);
                    end
                end
            end
        end

        // R6 R7 R8 R9 R10: unary operations, B ignored
        foreach (uops[k]) begin
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 2; c++) begin
                    set_cz(c[0], a[0]);
                    do_op(uops[k], a, a ^ 8'h5A, 1'b1);
                end
            end
        end

        // R12: unused codes and idle cycles
        for (int op = 19; op < 32; op++) begin
            set_cz(1'b1, 1'b0);
            do_op(op, 8'h80, 8'h80, 1'b1);
        end
        set_cz(1'b1, 1'b1);
        do_op(0, 8'h80, 8'h80, 1'b0);
        do_op(8, 8'h01, 8'h00, 1'b0);
        set_cz(1'b0, 1'b0);
        do_op(7, 8'hFF, 8'h00, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule